// File: doc/BRIEF.md
# Aliased Control and Status Register Bank

This block is the register front end of a four-channel coprocessor. Software reaches it through a plain 32-bit read/write port. Each register has a base word and three alias words right after it. A write to an alias ORs ones into the register, removes the bits written as one, or flips the bits written as one. Because of this, software never needs a read-modify-write to change a single field.

The bank holds four kinds of register:
- a global control register, carrying a soft reset, a clock gate, three feature enables and the per-channel interrupt enables;
- a status register that merges the per-channel interrupt pending flags with live engine-side status;
- a channel control register with per-channel enable, per-channel priority and an interrupt-merge bit;
- a group of four 32-bit registers for each channel, placed at a fixed stride.

The engine raises a one-cycle done pulse per channel. That pulse latches a pending flag. The interrupt output is high whenever any pending flag is high and its enable is high.

Top module: `scr_bank`

## Requirements
- R1: A write to a register's base word (address bits 3:2 = 00) replaces every writable bit of the register with the write data.
- R2: A write to base+0x4 ORs the data into the register's writable bits.
- R3: A write to base+0x8 clears each writable bit for which the data bit is one.
- R4: A write to base+0xC inverts each writable bit for which the data bit is one.
- R5: After reset, the global control register (offset 0x000) reads 0x7000_0000: the clock gate (bit 30) is one and the two capability bits are one. Every other register reads zero, and the irq output is low.
- R6: In global control, bits 31, 30, 23:21 and 3:0 are writable. Bits 29 and 28 always read one. All other bits read zero.
- R7: The status register (offset 0x010) reads as follows:
  - bit 28 is the key-ready input;
  - bits 27:24 are the current-channel input;
  - bits 19:16 are the ready-channel input;
  - bits 3:0 are the pending flags.
- R8: A one-cycle done pulse on channel n sets pending bit n. Writing a one to bit n through offset 0x018 clears it. Plain, set and toggle writes to the status register leave the pending bits unchanged.
- R9: When a done pulse and a clear write for the same channel fall in the same cycle, the pending bit ends up set.
- R10: irq is high exactly when some channel has both its pending bit and its global-control enable (bit n) high.
- R11: Channel n has four fully writable 32-bit registers at 0x100, 0x110, 0x120 and 0x130 plus n*0x40. Each of them has the same three aliases.
- R12: In channel control (offset 0x020), bits 16, 11:8 and 3:0 are writable and all other bits read zero. Bits 3:0 drive chan_en, bits 11:8 drive chan_hiprio, and bit 16 drives ch0_irq_merge.
- R13: While global control bit 31 is one, all other registers and the pending flags are held at their reset values, and writes and done pulses are ignored. Global control itself stays writable. Clearing bit 31 through the 0x008 alias makes the bank writable again.
- R14: Reads of undefined offsets (for example 0x040 or 0x200) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| chan_done | input | 4 | One-cycle done pulse per channel |
| ready_chan | input | 4 | Engine ready-channel status |
| cur_chan | input | 4 | Engine current-channel status |
| key_ready | input | 1 | Engine key-ready status |
| soft_rst | output | 1 | Global control bit 31 |
| clk_gate | output | 1 | Global control bit 30 |
| feat_en | output | 3 | Global control bits 23:21 |
| chan_en | output | 4 | Channel control bits 3:0 |
| chan_hiprio | output | 4 | Channel control bits 11:8 |
| ch0_irq_merge | output | 1 | Channel control bit 16 |
| irq | output | 1 | Combined channel interrupt |

## Verification
The alias operations are tried on a channel register holding a mixed bit pattern. The data is chosen so that set, clear and toggle each produce a value that none of the other operations could produce.

The same operations are repeated on global control and channel control with all-ones data. This separates writable bits from read-only and reserved bits.

The pending logic is driven with lone done pulses, with clear writes on enabled and disabled channels, and with a pulse and a clear in the same cycle. Together these separate set priority from clear priority and show that irq is gated by the enables. A soft-reset episode then shows that state is wiped, that writes are blocked while it lasts, and that the bank works again once it is released.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } alias_op_e;

  function automatic logic [REG_W-1:0] apply_alias(
    input alias_op_e op,
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] data
  );
    case (op)
      OP_WRITE:  return data;
      OP_SET:    return cur | data;
      OP_CLEAR:  return cur & ~data;
      default:   return cur ^ data;
    endcase
  endfunction
endpackage

// File: rtl/scr_alias_reg.sv
module scr_alias_reg
  import scr_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = '0,
  parameter logic [REG_W-1:0] WR_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_rst,
  input  logic             we,
  input  alias_op_e        op,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] nxt;
  assign nxt = apply_alias(op, q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= RST_VAL;
    else if (hold_rst) q <= RST_VAL;
    else if (we)       q <= (q & ~WR_MASK) | (nxt & WR_MASK);
  end

  AST_HOLD_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> (q == RST_VAL)); // R13

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_rst && !we) |=> $stable(q)); // R14
endmodule

// File: rtl/scr_chan_bank.sv
module scr_chan_bank
  import scr_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CH_SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold_rst,
  input  logic                       we,
  input  alias_op_e                  op,
  input  logic [CH_SEL_W-1:0]        ch_idx,
  input  logic [1:0]                 reg_idx,
  input  logic [REG_W-1:0]           wdata,
  output logic [NCH*4-1:0][REG_W-1:0] regs_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < 4; r++) begin : g_reg
      logic sel_we;
      assign sel_we = we && (ch_idx == CH_SEL_W'(c)) && (reg_idx == 2'(r));
      scr_alias_reg #(.RST_VAL('0), .WR_MASK('1)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_rst (hold_rst),
        .we       (sel_we),
        .op       (op),
        .wdata    (wdata),
        .q        (regs_q[c*4+r])
      );
    end
  end
endmodule

// File: rtl/scr_pend.sv
module scr_pend #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_rst,
  input  logic [NCH-1:0] done,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  input  logic [NCH-1:0] en,
  output logic [NCH-1:0] pend,
  output logic           irq
);
  logic [NCH-1:0] kill;
  assign kill = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= '0;
    else if (hold_rst) pend <= '0;
    else               pend <= (pend & ~kill) | done;
  end

  assign irq = |(pend & en);

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_rst && (done != '0)) |=> ((pend & $past(done)) == $past(done))); // R9

  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_rst && !clr_we) |=> ((pend & $past(pend)) == $past(pend))); // R8

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0)); // R10
endmodule

// File: rtl/scr_bank.sv
module scr_bank
  import scr_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]    chan_done,
  input  logic [NCH-1:0]    ready_chan,
  input  logic [3:0]        cur_chan,
  input  logic              key_ready,
  output logic              soft_rst,
  output logic              clk_gate,
  output logic [2:0]        feat_en,
  output logic [NCH-1:0]    chan_en,
  output logic [NCH-1:0]    chan_hiprio,
  output logic              ch0_irq_merge,
  output logic              irq
);
  localparam int CH_SEL_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int STRIDE_SH = 6;
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] OFS_CC   = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] CH_BASE  = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] CH_END   = ADDR_W'(12'h100 + NCH * (1 << STRIDE_SH));
  localparam logic [REG_W-1:0]  CH_BITS  = REG_W'((1 << NCH) - 1);
  localparam logic [REG_W-1:0]  CTRL_MASK = 32'hC0E0_0000 | CH_BITS;
  localparam logic [REG_W-1:0]  CTRL_RST  = 32'h4000_0000;
  localparam logic [REG_W-1:0]  CAP_BITS  = 32'h3000_0000;
  localparam logic [REG_W-1:0]  CC_MASK   = 32'h0001_0000 | (CH_BITS << 8) | CH_BITS;

  alias_op_e op;
  logic [ADDR_W-1:0] base, ch_off;
  logic hit_ctrl, hit_stat, hit_cc, hit_ch;
  logic [CH_SEL_W-1:0] ch_idx;
  logic [1:0] reg_idx;

  assign op       = alias_op_e'(bus_addr[3:2]);
  assign base     = {bus_addr[ADDR_W-1:4], 4'b0000};
  assign hit_ctrl = (base == OFS_CTRL);
  assign hit_stat = (base == OFS_STAT);
  assign hit_cc   = (base == OFS_CC);
  assign hit_ch   = (base >= CH_BASE) && (base < CH_END);
  assign ch_off   = base - CH_BASE;
  assign ch_idx   = ch_off[STRIDE_SH +: CH_SEL_W];
  assign reg_idx  = ch_off[5:4];

  logic [REG_W-1:0] ctrl_q, cc_q;
  logic             hold;
  logic [NCH-1:0]   pend;
  logic [NCH*4-1:0][REG_W-1:0] ch_q;

  assign hold = ctrl_q[31];

  scr_alias_reg #(.RST_VAL(CTRL_RST), .WR_MASK(CTRL_MASK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_rst(1'b0),
    .we(bus_wr && hit_ctrl), .op(op), .wdata(bus_wdata), .q(ctrl_q)
  );

  scr_alias_reg #(.RST_VAL('0), .WR_MASK(CC_MASK)) u_cc (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold),
    .we(bus_wr && hit_cc), .op(op), .wdata(bus_wdata), .q(cc_q)
  );

  scr_chan_bank #(.NCH(NCH)) u_chans (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold),
    .we(bus_wr && hit_ch), .op(op), .ch_idx(ch_idx), .reg_idx(reg_idx),
    .wdata(bus_wdata), .regs_q(ch_q)
  );

  scr_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold),
    .done(chan_done),
    .clr_we(bus_wr && hit_stat && (op == OP_CLEAR)),
    .clr_mask(bus_wdata[NCH-1:0]),
    .en(ctrl_q[NCH-1:0]),
    .pend(pend), .irq(irq)
  );

  logic [REG_W-1:0] stat_rd;
  always_comb begin
    stat_rd            = '0;
    stat_rd[28]        = key_ready;
    stat_rd[27:24]     = cur_chan;
    stat_rd[16 +: NCH] = ready_chan;
    stat_rd[NCH-1:0]   = pend;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_q | CAP_BITS;
    else if (hit_stat) bus_rdata = stat_rd;
    else if (hit_cc)   bus_rdata = cc_q;
    else if (hit_ch)   bus_rdata = ch_q[{ch_idx, reg_idx}];
  end

  assign soft_rst      = ctrl_q[31];
  assign clk_gate      = ctrl_q[30];
  assign feat_en       = ctrl_q[23:21];
  assign chan_en       = cc_q[NCH-1:0];
  assign chan_hiprio   = cc_q[8 +: NCH];
  assign ch0_irq_merge = cc_q[16];

  AST_CAP_BITS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctrl |-> (bus_rdata[29:28] == 2'b11)); // R6

  AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_ctrl || hit_stat || hit_cc || hit_ch) |-> (bus_rdata == '0)); // R14

  AST_SRST_CLEARS_CC: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (chan_en == '0 && chan_hiprio == '0)); // R13
endmodule

// File: tb/scr_bank_bench.sv
module scr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  localparam logic [11:0] V_WA [NV] = '{12'h100, 12'h104, 12'h108, 12'h10C, 12'h1D0,
    12'h164, 12'h020, 12'h028, 12'h000, 12'h004, 12'h00C, 12'h040, 12'h200};
  localparam logic [31:0] V_WD [NV] = '{32'h1234_5678, 32'h0000_0F00, 32'h1200_0008,
    32'hFF00_0000, 32'hA5A5_0001, 32'h0000_00F0, 32'hFFFF_FFFF, 32'h0000_0F05,
    32'h0000_0000, 32'h00E0_000F, 32'h0020_0003, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [11:0] V_RA [NV] = '{12'h100, 12'h100, 12'h100, 12'h100, 12'h1D0,
    12'h160, 12'h020, 12'h020, 12'h000, 12'h000, 12'h000, 12'h040, 12'h200};
  localparam logic [31:0] V_EX [NV] = '{32'h1234_5678, 32'h1234_5F78, 32'h0034_5F70,
    32'hFF34_5F70, 32'hA5A5_0001, 32'h0000_00F0, 32'h0001_0F0F, 32'h0001_000A,
    32'h3000_0000, 32'h30E0_000F, 32'h30C0_000C, 32'h0000_0000, 32'h0000_0000};
  localparam string V_RQ [NV] = '{"R1 R11", "R2", "R3", "R4", "R11", "R2 R11", "R12",
    "R3 R12", "R6", "R2 R6", "R4 R6", "R14", "R14"};

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  chan_done = '0, ready_chan = '0, cur_chan = '0;
  logic        key_ready = 0;
  logic        soft_rst, clk_gate, ch0_irq_merge, irq;
  logic [2:0]  feat_en;
  logic [3:0]  chan_en, chan_hiprio;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_bank u_scr_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_done(chan_done),
    .ready_chan(ready_chan), .cur_chan(cur_chan), .key_ready(key_ready),
    .soft_rst(soft_rst), .clk_gate(clk_gate), .feat_en(feat_en),
    .chan_en(chan_en), .chan_hiprio(chan_hiprio),
    .ch0_irq_merge(ch0_irq_merge), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    chan_done = m;
    @(negedge clk);
    chan_done = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 reset state
    rd_chk("R5 ctrl", 12'h000, 32'h7000_0000);
    rd_chk("R5 cc", 12'h020, 32'h0);
    rd_chk("R5 ch", 12'h100, 32'h0);
    rd_chk("R5 stat", 12'h010, 32'h0);
    chk("R5 irq", {31'b0, irq}, 32'h0);
    chk("R5 clk_gate", {31'b0, clk_gate}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      wr(V_WA[i], V_WD[i]);
      rd_chk(V_RQ[i], V_RA[i], V_EX[i]);
    end
    chk("R12 chan_en", {28'b0, chan_en}, 32'hA);
    chk("R6 feat_en", {29'b0, feat_en}, 32'h6);
    rd_chk("R14 no side effect", 12'h100, 32'hFF34_5F70);

    // R7 status inputs
    ready_chan = 4'h5; cur_chan = 4'h2; key_ready = 1;
    rd_chk("R7", 12'h010, 32'h1205_0000);
    ready_chan = '0; cur_chan = '0; key_ready = 0;

    // R8 / R10 pending and irq (enables = 4'hC)
    pulse(4'h4);
    rd_chk("R8 set", 12'h010, 32'h4);
    chk("R10 irq on", {31'b0, irq}, 32'h1);
    pulse(4'h1);
    wr(12'h018, 32'h4);
    rd_chk("R8 clear", 12'h010, 32'h1);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(12'h010, 32'hF);
    wr(12'h014, 32'hF);
    wr(12'h01C, 32'h1);
    rd_chk("R8 other writes", 12'h010, 32'h1);

    // R9 set beats clear
    @(negedge clk);
    bus_wr = 1; bus_addr = 12'h018; bus_wdata = 32'h1; chan_done = 4'h1;
    @(negedge clk);
    bus_wr = 0; chan_done = '0;
    rd_chk("R9", 12'h010, 32'h1);
    wr(12'h018, 32'h1);
    rd_chk("R8 cleared", 12'h010, 32'h0);
    pulse(4'h8);
    chk("R10 irq ch3", {31'b0, irq}, 32'h1);

    // R13 soft reset
    wr(12'h004, 32'h8000_0000);
    chk("R13 soft_rst", {31'b0, soft_rst}, 32'h1);
    rd_chk("R13 ch wiped", 12'h100, 32'h0);
    rd_chk("R13 cc wiped", 12'h020, 32'h0);
    rd_chk("R13 pend wiped", 12'h010, 32'h0);
    chk("R13 irq", {31'b0, irq}, 32'h0);
    wr(12'h100, 32'h0000_DEAD);
    pulse(4'h4);
    rd_chk("R13 write ignored", 12'h100, 32'h0);
    rd_chk("R13 done ignored", 12'h010, 32'h0);
    wr(12'h008, 32'hC000_0000);
    rd_chk("R13 ctrl kept", 12'h000, 32'h30C0_000C);
    wr(12'h100, 32'h0000_0055);
    rd_chk("R13 resumed", 12'h100, 32'h0000_0055);

    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule